// File: doc/BRIEF.md
# Squaring-Loop BPSK Carrier Regenerator

This block rebuilds a clean carrier reference from a sampled binary phase-shift keyed signal. A 180-degree data flip only negates the waveform, so squaring each sample removes the data and leaves a tone at twice the carrier plus a DC term. A symmetric band-pass FIR centred on twice the carrier removes the DC and the out-of-band products. The sign of the filtered tone is debounced, and each confirmed rising crossing toggles a flip-flop, which halves the frequency back to the carrier. A short low-pass FIR then rounds the resulting square wave into a sine-like signed reference.

The clock input is the sample clock, with one new sample on every edge. In the target system that is 8 MHz, with a 500 kHz carrier (fs/16) and 100 kbit/s data. Both outputs are the recovered carrier: a one-bit square wave and a signed filtered value. Downstream mixing and symbol decisions are handled elsewhere. The two filters use a folded multiply stage and a registered adder tree. Their latency is `fir_latency(taps)` = clog2((taps+1)/2) + 2 cycles, which gives 6 for the band-pass filter and 5 for the low-pass filter.

Top module: `carrier_regen`

## Requirements
- R1: While rst_ni is low, carrier_sq_o is 0 and carrier_o is 0.
- R2: Each sample is squared before filtering, so negating every input sample leaves both outputs unchanged cycle for cycle.
- R3: The band-pass value after edge m is B(m) = sum over k=0..30 of h(k)*x(m-6-k)^2. Here x(j) is the sample taken at edge j, counting from the first edge after reset, and x(j)=0 for j<0. The coefficients are h(k) = (16-|k-15|)*c((k-15) mod 8), where c(0..7) = 256, 181, 0, -181, -256, -181, 0, 181.
- R4: A sign counts as nonnegative when B >= 0. A new sign is confirmed at edge m only when B(m-1) and B(m-2) have the same sign and that sign differs from the current confirmed sign. B(j<0) counts as nonnegative. The confirmed sign resets to nonnegative, so a one-sample excursion never confirms.
- R5: carrier_sq_o toggles, taking effect after edge m, exactly when nonnegative is confirmed at edge m. A confirmation of negative leaves it unchanged.
- R6: The low-pass input at edge j is u(j) = +CAR_AMP if carrier_sq_o was 1 before edge j, and -CAR_AMP otherwise. u(j<0) = 0. carrier_o after edge m = sum over k=0..14 of (8-|k-7|)*u(m-5-k). The default CAR_AMP is 1024.
- R7: For a steady tone of amplitude 1500 at any frequency from 0.05625 to 0.06875 of the sample rate (450 to 550 kHz at 8 MHz), carrier_sq_o changes 2*f/fs times per sample within ±2 over a 1600-sample window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, one sample per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | X_W (12) | Signed input sample |
| carrier_sq_o | output | 1 | Recovered carrier as a square wave |
| carrier_o | output | C_W (24) | Recovered carrier after low-pass filtering, signed |

## Verification
The hardest condition to reach is a band-pass output whose sign flips for only a single sample. A clean tone crosses zero slowly, and the hysteresis exists only for that one-sample case. To reach it, the stimulus uses sparse impulses of different amplitudes and signs, whose responses replay the alternating coefficient signs. It also adds random noise to a phase-flipping signal, which jitters the crossings sample by sample. A separate run feeds the same noisy sequence negated and compares the two output traces cycle for cycle. Tones at the band edges and the centre then check the division ratio.

// File: rtl/carrier_regen_pkg.sv
package carrier_regen_pkg;

  typedef enum logic {FIR_BAND = 1'b0, FIR_LOW = 1'b1} fir_kind_e;

  // eight-phase cosine, scale 256
  function automatic int cos8(input int ph);
    case (ph)
      0:       return 256;
      1:       return 181;
      2:       return 0;
      3:       return -181;
      4:       return -256;
      5:       return -181;
      6:       return 0;
      default: return 181;
    endcase
  endfunction

  function automatic int fir_coef(input fir_kind_e kind, input int taps, input int k);
    int mid;
    int off;
    int mag;
    mid = (taps - 1) / 2;
    off = k - mid;
    mag = (off < 0) ? -off : off;
    if (kind == FIR_BAND) return (mid + 1 - mag) * cos8(((off % 8) + 8) % 8);
    return mid + 1 - mag;
  endfunction

  function automatic int fir_latency(input int taps);
    return $clog2((taps + 1) / 2) + 2;
  endfunction

endpackage

// File: rtl/carrier_regen_fir.sv
module carrier_regen_fir
  import carrier_regen_pkg::*;
#(
  parameter fir_kind_e KIND  = FIR_BAND,
  parameter int        TAPS  = 31,
  parameter int        IN_W  = 24,
  parameter int        ACC_W = 48
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  in_i,
  output logic signed [ACC_W-1:0] y_o
);

  localparam int FOLD   = (TAPS + 1) / 2;
  localparam int DEPTH  = $clog2(FOLD);
  localparam int LEAVES = 2 ** DEPTH;

  logic signed [IN_W-1:0]  tap_q  [TAPS];
  logic signed [ACC_W-1:0] pre_d  [FOLD];
  logic signed [ACC_W-1:0] pre_q  [FOLD];
  logic signed [ACC_W-1:0] prod_d [LEAVES];
  logic signed [ACC_W-1:0] node_q [1:2*LEAVES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) tap_q[i] <= '0;
    end else begin
      tap_q[0] <= in_i;
      for (int i = 1; i < TAPS; i++) tap_q[i] <= tap_q[i-1];
    end
  end

  // fold symmetric taps, then constant multiply
  for (genvar i = 0; i < FOLD; i++) begin : g_fold
    localparam int COEF = fir_coef(KIND, TAPS, i);
    logic signed [ACC_W-1:0] coef_w;
    assign coef_w = ACC_W'(COEF);
    if (2 * i == TAPS - 1) begin : g_mid
      assign pre_d[i] = ACC_W'(tap_q[i]);
    end else begin : g_pair
      assign pre_d[i] = ACC_W'(tap_q[i]) + ACC_W'(tap_q[TAPS-1-i]);
    end
    assign prod_d[i] = pre_q[i] * coef_w;
  end

  for (genvar i = FOLD; i < LEAVES; i++) begin : g_pad
    assign prod_d[i] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < FOLD; i++) pre_q[i] <= '0;
      for (int n = 1; n < 2 * LEAVES; n++) node_q[n] <= '0;
    end else begin
      for (int i = 0; i < FOLD; i++) pre_q[i] <= pre_d[i];
      for (int n = 1; n < LEAVES; n++) node_q[n] <= node_q[2*n] + node_q[2*n+1];
      for (int i = 0; i < LEAVES; i++) node_q[LEAVES+i] <= prod_d[i];
    end
  end

  assign y_o = node_q[1];

endmodule

// File: rtl/carrier_regen_zc.sv
module carrier_regen_zc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nonneg_i,
  output logic toggle_o
);

  logic prev_q;
  logic pos_q;
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      pos_q  <= 1'b1;
      tog_q  <= 1'b0;
    end else begin
      prev_q <= nonneg_i;
      // two matching samples confirm a new sign
      if (nonneg_i == prev_q && nonneg_i != pos_q) begin
        pos_q <= nonneg_i;
        if (nonneg_i) tog_q <= ~tog_q;
      end
    end
  end

  assign toggle_o = tog_q;

endmodule

// File: rtl/carrier_regen.sv
module carrier_regen
  import carrier_regen_pkg::*;
#(
  parameter int X_W      = 12,
  parameter int C_W      = 24,
  parameter int BP_ACC_W = 48,
  parameter int BP_TAPS  = 31,
  parameter int LP_TAPS  = 15,
  parameter int CAR_AMP  = 1024
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic signed [X_W-1:0] sample_i,
  output logic                  carrier_sq_o,
  output logic signed [C_W-1:0] carrier_o
);

  localparam int LP_LATENCY = fir_latency(LP_TAPS);

  logic signed [2*X_W-1:0]    sq_w;
  logic signed [BP_ACC_W-1:0] band_y;
  logic                       band_nonneg;
  logic                       tog;
  logic signed [X_W-1:0]      lp_in;

  assign sq_w = sample_i * sample_i;

  carrier_regen_fir #(
    .KIND(FIR_BAND), .TAPS(BP_TAPS), .IN_W(2*X_W), .ACC_W(BP_ACC_W)
  ) u_bpf (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(sq_w), .y_o(band_y)
  );

  assign band_nonneg = (band_y >= 0);

  carrier_regen_zc u_zc (
    .clk_i(clk_i), .rst_ni(rst_ni), .nonneg_i(band_nonneg), .toggle_o(tog)
  );

  assign lp_in = tog ? X_W'(CAR_AMP) : X_W'(-CAR_AMP);

  carrier_regen_fir #(
    .KIND(FIR_LOW), .TAPS(LP_TAPS), .IN_W(X_W), .ACC_W(C_W)
  ) u_lpf (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(lp_in), .y_o(carrier_o)
  );

  assign carrier_sq_o = tog;

endmodule

// File: rtl/carrier_regen_chk.sv
module carrier_regen_chk #(
  parameter int C_W     = 24,
  parameter int LP_TAPS = 15,
  parameter int LP_LAT  = 5,
  parameter int CAR_AMP = 1024
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  carrier_sq_o,
  input logic signed [C_W-1:0] carrier_o,
  input logic                  band_nonneg
);

  localparam int PEAK = CAR_AMP * ((LP_TAPS + 1) / 2) * ((LP_TAPS + 1) / 2);
  localparam int SLEW = CAR_AMP * (LP_TAPS + 1);

  int cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= 0;
    else if (cnt_q <= LP_LAT) cnt_q <= cnt_q + 1;
  end

  AST_SQ_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(carrier_sq_o) |=> $stable(carrier_sq_o) ##1 $stable(carrier_sq_o) ##1 $stable(carrier_sq_o)); // R4

  AST_SQ_CONFIRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(carrier_sq_o) |-> $past(band_nonneg, 1) && $past(band_nonneg, 2)); // R5

  AST_CAR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(carrier_o) <= PEAK) && (int'(carrier_o) >= -PEAK)); // R6

  AST_CAR_SLEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int'(carrier_o) - int'($past(carrier_o))) <= SLEW) &&
    ((int'(carrier_o) - int'($past(carrier_o))) >= -SLEW)); // R6

  AST_CAR_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= LP_LAT) |-> (carrier_o == '0)); // R6

endmodule

bind carrier_regen carrier_regen_chk #(
  .C_W(C_W), .LP_TAPS(LP_TAPS), .LP_LAT(LP_LATENCY), .CAR_AMP(CAR_AMP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .carrier_sq_o(carrier_sq_o),
  .carrier_o(carrier_o), .band_nonneg(band_nonneg)
);

// File: tb/carrier_regen_tb_top.sv
`timescale 1ns/1ps
module carrier_regen_tb_top;

  localparam int X_W  = 12;
  localparam int C_W  = 24;
  localparam int AMP  = 1024;
  localparam int LB   = 6;
  localparam int LL   = 5;
  localparam int NB   = 1200;
  localparam real PI  = 3.14159265358979;

  typedef struct {
    int     idx;
    bit     sq;
    longint car;
  } exp_t;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic signed [X_W-1:0] sample = '0;
  logic                  carrier_sq;
  logic signed [C_W-1:0] carrier;

  int     checks = 0;
  int     errors = 0;
  bit     done = 1'b0;
  int     m = 0;
  bit     pos_m = 1'b1;
  bit     tog_m = 1'b0;
  exp_t   q [$];
  longint xs      [16384];
  bit     s_arr   [16384];
  bit     tog_arr [16384];
  bit     act_sq  [16384];
  longint act_car [16384];
  bit     ref_sq  [NB];
  longint ref_car [NB];
  int     bpsk    [NB];

  always #5 clk = ~clk;

  carrier_regen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample),
    .carrier_sq_o(carrier_sq), .carrier_o(carrier)
  );

  function automatic longint hb(input int k);
    int off;
    int mag;
    longint c;
    off = k - 15;
    mag = (off < 0) ? -off : off;
    case (((off % 8) + 8) % 8)
      0: c = 256;   1: c = 181;  2: c = 0;    3: c = -181;
      4: c = -256;  5: c = -181; 6: c = 0;    default: c = 181;
    endcase
    return (16 - mag) * c;
  endfunction

  function automatic longint hl(input int k);
    return 8 - ((k < 7) ? 7 - k : k - 7);
  endfunction

  function automatic longint u_at(input int j);
    if (j < 0) return 0;
    if (j == 0) return -AMP;
    return tog_arr[j-1] ? AMP : -AMP;
  endfunction

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // driver: apply a sample, predict outputs after the edge, push expectation
  task automatic step(input int x);
    longint y;
    longint car;
    bit p1;
    bit p2;
    exp_t it;
    sample = X_W'(x);
    xs[m] = x;
    @(posedge clk);
    #1;
    y = 0;
    for (int k = 0; k < 31; k++)
      if (m - LB - k >= 0) y += hb(k) * xs[m-LB-k] * xs[m-LB-k];
    s_arr[m] = (y >= 0);
    p1 = (m >= 1) ? s_arr[m-1] : 1'b1;
    p2 = (m >= 2) ? s_arr[m-2] : 1'b1;
    if (p1 == p2 && p1 != pos_m) begin
      pos_m = p1;
      if (p1) tog_m = ~tog_m;
    end
    tog_arr[m] = tog_m;
    car = 0;
    for (int k = 0; k < 15; k++) car += hl(k) * u_at(m - LL - k);
    it.idx = m;
    it.sq  = tog_m;
    it.car = car;
    q.push_back(it);
    m++;
    @(negedge clk);
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t it;
      longint act;
      it = q.pop_front();
      act = longint'(carrier);
      act_sq[it.idx]  = carrier_sq;
      act_car[it.idx] = act;
      check(carrier_sq == it.sq, $sformatf("R5 (R3 R4) carrier_sq_o at %0d actual %0b expected %0b",
                                           it.idx, carrier_sq, it.sq));
      check(act == it.car, $sformatf("R6 carrier_o at %0d actual %0d expected %0d",
                                     it.idx, act, it.car));
    end
  end

  task automatic do_reset();
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    sample = '0;
    q.delete();
    @(negedge clk);
    @(negedge clk);
    #1;
    check(carrier_sq == 1'b0, $sformatf("R1 carrier_sq_o in reset actual %0b expected 0", carrier_sq));
    check(carrier == '0, $sformatf("R1 carrier_o in reset actual %0d expected 0", carrier));
    @(negedge clk);
    #2;
    rst_n = 1'b1;
    m = 0;
    pos_m = 1'b1;
    tog_m = 1'b0;
  endtask

  task automatic run_tone(input real f);
    int base;
    int flips;
    int want;
    base = m;
    for (int n = 0; n < 1900; n++) step($rtoi(1500.0 * $cos(2.0 * PI * f * n)));
    #1;
    flips = 0;
    for (int i = base + 300; i < base + 1900; i++)
      if (act_sq[i] != act_sq[i-1]) flips++;
    want = $rtoi(2.0 * f * 1600.0 + 0.5);
    check(flips >= want - 2 && flips <= want + 2,
          $sformatf("R7 toggles at f=%0f actual %0d expected %0d", f, flips, want));
  endtask

  initial begin
    int bad;
    int dsign;
    for (int n = 0; n < NB; n++) begin
      if (n % 80 == 0) dsign = ($urandom & 1) ? 1 : -1;
      bpsk[n] = dsign * $rtoi(1500.0 * $cos(2.0 * PI * n / 16.0)) + int'($urandom_range(16)) - 8;
    end

    do_reset();

    // R3: isolated impulses replay the band-pass coefficient signs
    foreach (bpsk[i]) begin end
    begin
      int amps [5] = '{2047, -2047, 900, 1, -1500};
      foreach (amps[i]) begin
        step(amps[i]);
        for (int z = 0; z < 59; z++) step(0);
      end
    end

    // R4: noisy phase-flipping carrier
    do_reset();
    for (int n = 0; n < NB; n++) step(bpsk[n]);
    #1;
    for (int n = 0; n < NB; n++) begin
      ref_sq[n]  = act_sq[n];
      ref_car[n] = act_car[n];
    end

    // R2: negated copy of the same sequence
    do_reset();
    for (int n = 0; n < NB; n++) step(-bpsk[n]);
    #1;
    bad = 0;
    for (int n = 0; n < NB; n++)
      if (act_sq[n] != ref_sq[n] || act_car[n] != ref_car[n]) bad++;
    check(bad == 0, $sformatf("R2 trace mismatches under negation actual %0d expected 0", bad));

    // R7: band edges and centre
    do_reset();
    run_tone(0.05625);
    run_tone(0.06875);
    run_tone(0.0625);

    #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule